// File: doc/BRIEF.md
# Protected sector write sequencer

This block models the write-side front end of a byte-wide parallel nonvolatile memory whose programming can be locked by software. It samples the asynchronous chip-enable, write-enable and output-enable strobes and the address and data buses into the system clock domain. It recognises byte-load cycles and separates command bytes from data bytes. Data bytes for one sector are gathered into a buffer that carries a per-byte valid mask. When the strobes fall quiet, the block starts an internal program timer.

Programming can be locked. A three-byte command both locks the block and opens one writable load window. A six-byte command unlocks it again. While the block is locked, a write without the command prefix still occupies the device for the full program time, but it commits nothing. The busy output marks the program period, during which reads are meant to be status polls. The commit pulse tells the downstream array model that the buffered sector must be written.

Top module: `sector_write_seq`

## Requirements
- R1: A byte load takes place only when chip-enable and write-enable are both low while output-enable is high at the moment the later of the two falls. The load completes when the first of the two rises. A pulse made with output-enable low has no effect.
- R2: The address is taken when the later of chip-enable and write-enable falls. The data is the value on the bus just before the first of the two rises.
- R3: The bytes 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 turn protection on. The data loads that follow them form a window that is committed.
- R4: A byte that does not match the next expected command byte sends the matcher back to its start and is handled as an ordinary data load.
- R5: While protection is on, a data load with no unlock prefix opens a window and then a full program period. No commit pulse is given, and the buffer, mask and sector address are left unchanged.
- R6: The six bytes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 turn protection off. The data loads that follow are committed.
- R7: With protection off, plain data loads are committed. Protection is off after reset.
- R8: The sector address is addr[14:6] of the first data byte of a window. Each byte is stored at offset addr[5:0] (bits [8*off+7:8*off] of buf_data_o) and sets valid bit off. The mask is cleared when a committing window opens. Loads to another sector within the same window are ignored.
- R9: The load window closes IDLE_CLKS cycles after the last completed load. A load that completes in the same cycle as the close keeps the window open.
- R10: busy_o is high for exactly PROG_CLKS cycles after a window closes. For a committing window, commit_o pulses for one cycle, in the first busy cycle.
- R11: Byte loads that complete while busy_o is high are ignored.
- R12: After reset busy_o and commit_o are low, and the mask and sector address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write-enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable strobe, active low, asynchronous |
| addr_i | input | 15 | Byte address bus |
| data_i | input | 8 | Data bus |
| sect_addr_o | output | 9 | Sector address of the last committed window |
| buf_data_o | output | 512 | Sector byte buffer, byte n at bits [8n+7:8n] |
| buf_valid_o | output | 64 | Per-byte valid mask |
| commit_o | output | 1 | One-cycle pulse: program the buffered sector |
| busy_o | output | 1 | Program period in progress |

## Verification
Two events can land on the same clock edge: the completion of a byte load and the expiry of the idle timer that closes the window. The bench sends pairs of loads whose completions are separated by gaps from IDLE_CLKS-2 to IDLE_CLKS+2 cycles. At a gap of IDLE_CLKS both events fall on the same edge. A gap up to and including IDLE_CLKS must leave both bytes in the committed mask. A longer gap must leave only the first byte, with exactly one program period and no second window.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} sws_state_e;
  localparam logic [14:0] CMD_ADR_HI = 15'h5555;
  localparam logic [14:0] CMD_ADR_LO = 15'h2AAA;
  localparam logic [7:0]  CMD_KEY1   = 8'hAA;
  localparam logic [7:0]  CMD_KEY2   = 8'h55;
  localparam logic [7:0]  CMD_LOCK   = 8'hA0;
  localparam logic [7:0]  CMD_EXT    = 8'h80;
  localparam logic [7:0]  CMD_UNLOCK = 8'h20;
endpackage

// File: rtl/sws_strobe_front.sv
module sws_strobe_front #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [1:0] ce_sy, we_sy, oe_sy;
  logic [ADDR_W-1:0] addr_s1, addr_s2;
  logic [DATA_W-1:0] data_s1, data_s2;
  logic low, low_q, armed_q;

  assign low = !ce_sy[1] && !we_sy[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_sy <= '1; we_sy <= '1; oe_sy <= '1;
      addr_s1 <= '0; addr_s2 <= '0; data_s1 <= '0; data_s2 <= '0;
      low_q <= 1'b0; armed_q <= 1'b0; addr_o <= '0; data_o <= '0;
    end else begin
      ce_sy <= {ce_sy[0], ce_n_i};
      we_sy <= {we_sy[0], we_n_i};
      oe_sy <= {oe_sy[0], oe_n_i};
      addr_s1 <= addr_i; addr_s2 <= addr_s1;
      data_s1 <= data_i; data_s2 <= data_s1;
      low_q <= low;
      // later falling strobe: latch address, qualify with OE
      if (low && !low_q) begin
        armed_q <= oe_sy[1];
        addr_o  <= addr_s2;
      end else if (!low || !oe_sy[1]) begin
        armed_q <= 1'b0;
      end
      if (low) data_o <= data_s2;
    end
  end

  // first rising strobe completes the load
  assign load_o = armed_q && low_q && !low && oe_sy[1];

  // R1
  load_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/sws_cmd_match.sv
module sws_cmd_match
  import sws_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              hit_o,
  output logic              unlock_o,
  output logic              disable_o
);
  logic [2:0] step_q;
  logic [ADDR_W-1:0] exp_a;
  logic [7:0] exp_d;
  logic at_a, ext;

  always_comb begin
    unique case (step_q)
      3'd0, 3'd3: begin exp_a = ADDR_W'(CMD_ADR_HI); exp_d = CMD_KEY1; end
      3'd1, 3'd4: begin exp_a = ADDR_W'(CMD_ADR_LO); exp_d = CMD_KEY2; end
      3'd2:       begin exp_a = ADDR_W'(CMD_ADR_HI); exp_d = CMD_LOCK; end
      default:    begin exp_a = ADDR_W'(CMD_ADR_HI); exp_d = CMD_UNLOCK; end
    endcase
  end

  assign at_a      = addr_i == exp_a;
  assign ext       = step_q == 3'd2 && at_a && data_i == CMD_EXT;
  assign hit_o     = en_i && ((at_a && data_i == exp_d) || ext);
  assign unlock_o  = en_i && step_q == 3'd2 && at_a && data_i == exp_d;
  assign disable_o = en_i && step_q == 3'd5 && at_a && data_i == exp_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else if (en_i) step_q <= (hit_o && !unlock_o && !disable_o) ? step_q + 3'd1 : 3'd0;
  end

  // R4
  mismatch_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit_o) |=> step_q == 3'd0);
  // R3
  lock_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> step_q == 3'd0);
endmodule

// File: rtl/sws_sector_buf.sv
module sws_sector_buf #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SECT_BYTES = 64,
  localparam int OFF_W     = $clog2(SECT_BYTES),
  localparam int SECT_W    = ADDR_W - OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         open_i,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [SECT_W-1:0]            sect_o,
  output logic [SECT_BYTES*DATA_W-1:0] data_o,
  output logic [SECT_BYTES-1:0]        valid_o
);
  logic [OFF_W-1:0] off;
  logic same, take;
  logic [DATA_W-1:0] byte_q [SECT_BYTES];

  assign off  = addr_i[OFF_W-1:0];
  assign same = addr_i[ADDR_W-1:OFF_W] == sect_o;
  assign take = open_i || (wr_i && same);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sect_o <= '0; valid_o <= '0;
    end else if (open_i) begin
      sect_o  <= addr_i[ADDR_W-1:OFF_W];
      valid_o <= SECT_BYTES'(1) << off;
    end else if (take) begin
      valid_o[off] <= 1'b1;
    end
  end

  for (genvar g = 0; g < SECT_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[g] <= '0;
      else if (take && off == OFF_W'(g)) byte_q[g] <= data_i;
    end
    assign data_o[g*DATA_W +: DATA_W] = byte_q[g];
  end

  // R8
  foreign_sect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !open_i && !same) |=> $stable(valid_o) && $stable(sect_o));
endmodule

// File: rtl/sector_write_seq.sv
module sector_write_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SECT_BYTES = 64,
  parameter int IDLE_CLKS  = 16,
  parameter int PROG_CLKS  = 40,
  localparam int OFF_W     = $clog2(SECT_BYTES),
  localparam int SECT_W    = ADDR_W - OFF_W,
  localparam int IC_W      = $clog2(IDLE_CLKS + 1),
  localparam int PC_W      = $clog2(PROG_CLKS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ce_n_i,
  input  logic                         we_n_i,
  input  logic                         oe_n_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [SECT_W-1:0]            sect_addr_o,
  output logic [SECT_BYTES*DATA_W-1:0] buf_data_o,
  output logic [SECT_BYTES-1:0]        buf_valid_o,
  output logic                         commit_o,
  output logic                         busy_o
);
  sws_state_e state_q;
  logic [IC_W-1:0] idle_cnt;
  logic [PC_W-1:0] prog_cnt;
  logic prot_q, unlocked_q, keep_q;
  logic load_v;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic match_en, hit, unlock, disable_seq, data_byte, open_win, wr_buf;

  sws_strobe_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk_i, .rst_ni, .ce_n_i, .we_n_i, .oe_n_i, .addr_i, .data_i,
    .load_o(load_v), .addr_o(ld_addr), .data_o(ld_data));

  assign match_en = load_v && state_q == ST_IDLE && !unlocked_q;

  sws_cmd_match #(.ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni, .en_i(match_en), .addr_i(ld_addr), .data_i(ld_data[7:0]),
    .hit_o(hit), .unlock_o(unlock), .disable_o(disable_seq));

  assign data_byte = load_v && state_q == ST_IDLE && (unlocked_q || !hit);
  assign open_win  = data_byte && (unlocked_q || !prot_q);
  assign wr_buf    = load_v && state_q == ST_LOAD && keep_q;

  sws_sector_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BYTES(SECT_BYTES)) u_buf (
    .clk_i, .rst_ni, .open_i(open_win), .wr_i(wr_buf), .addr_i(ld_addr),
    .data_i(ld_data), .sect_o(sect_addr_o), .data_o(buf_data_o), .valid_o(buf_valid_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; idle_cnt <= '0; prog_cnt <= '0;
      prot_q <= 1'b0; unlocked_q <= 1'b0; keep_q <= 1'b0; commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (unlock)      begin prot_q <= 1'b1; unlocked_q <= 1'b1; end
          if (disable_seq) begin prot_q <= 1'b0; unlocked_q <= 1'b1; end
          if (data_byte) begin
            state_q  <= ST_LOAD;
            keep_q   <= unlocked_q || !prot_q;
            idle_cnt <= '0;
          end
        end
        ST_LOAD: begin
          // a load in the closing cycle wins over the timeout
          if (load_v) idle_cnt <= '0;
          else if (idle_cnt == IC_W'(IDLE_CLKS - 1)) begin
            state_q    <= ST_PROG;
            prog_cnt   <= '0;
            commit_o   <= keep_q;
            unlocked_q <= 1'b0;
          end else idle_cnt <= idle_cnt + 1'b1;
        end
        default: begin
          if (prog_cnt == PC_W'(PROG_CLKS - 1)) state_q <= ST_IDLE;
          else prog_cnt <= prog_cnt + 1'b1;
        end
      endcase
    end
  end

  assign busy_o = state_q == ST_PROG;

  // R10
  commit_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> busy_o);
  // R10
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R11
  prog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(buf_valid_o) && $stable(sect_addr_o));
  // R5
  blocked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !keep_q) |=> $stable(buf_valid_o) && $stable(buf_data_o));
  // R3
  prot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_q) |-> $past(unlock));
  // R6
  prot_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(disable_seq));
endmodule

// File: tb/sector_write_seq_tb.sv
module sector_write_seq_tb;
  localparam int IDLE = 16;
  localparam int PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] data = '0;
  logic [8:0] sect;
  logic [511:0] bdata;
  logic [63:0] bvalid;
  logic commit, busy;

  int vectors = 0, fails = 0;
  int run = 0, last_len = 0, nbusy = 0, ncommit = 0, cyc = 0;
  bit done = 1'b0;

  sector_write_seq #(.IDLE_CLKS(IDLE), .PROG_CLKS(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .addr_i(addr), .data_i(data), .sect_addr_o(sect), .buf_data_o(bdata),
    .buf_valid_o(bvalid), .commit_o(commit), .busy_o(busy));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_len = run; nbusy++; run = 0; end
    if (commit) ncommit++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [14:0] a, input logic [7:0] d, input logic oe);
    @(negedge clk); addr = a; data = d; oe_n = oe;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_prog(output bit seen);
    int b0 = nbusy;
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (nbusy > b0) begin seen = 1'b1; break; end
    end
  endtask

  task automatic lock_seq();
    pulse(15'h5555, 8'hAA, 1'b1);
    pulse(15'h2AAA, 8'h55, 1'b1);
    pulse(15'h5555, 8'hA0, 1'b1);
  endtask

  function automatic logic [14:0] ad(input int s, input int o);
    return 15'((s << 6) | o);
  endfunction

  function automatic logic [7:0] bget(input int o);
    return bdata[o*8 +: 8];
  endfunction

  initial begin
    bit seen;
    int c0, b0;
    logic [63:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0 && commit == 0, "R12 strobes", {busy, commit}, 0);
    chk(bvalid == 0, "R12 mask", bvalid, 0);
    chk(sect == 0, "R12 sector", sect, 0);

    // R7 unprotected plain loads
    c0 = ncommit;
    pulse(ad(3, 0), 8'h3C, 1'b1);
    pulse(ad(3, 5), 8'h39, 1'b1);
    pulse(ad(3, 63), 8'h03, 1'b1);
    wait_prog(seen);
    chk(seen && ncommit == c0 + 1, "R7 commit", ncommit - c0, 1);
    chk(last_len == PROG, "R10 busy length", last_len, PROG);
    chk(sect == 3, "R8 sector", sect, 3);
    m = (64'd1 << 0) | (64'd1 << 5) | (64'd1 << 63);
    chk(bvalid == m, "R8 mask", bvalid, m);
    chk(bget(5) == 8'h39 && bget(63) == 8'h03, "R8 data", {bget(5), bget(63)}, 16'h3903);

    // R3 lock and write
    c0 = ncommit;
    lock_seq();
    pulse(ad(7, 1), 8'h71, 1'b1);
    pulse(ad(7, 2), 8'h72, 1'b1);
    wait_prog(seen);
    chk(ncommit == c0 + 1, "R3 commit", ncommit - c0, 1);
    m = 64'h6;
    chk(sect == 7 && bvalid == m, "R3 buffer", {sect, bvalid}, {9'd7, m});

    // R5 blocked write while protected
    c0 = ncommit;
    pulse(ad(9, 4), 8'h94, 1'b1);
    wait_prog(seen);
    chk(seen && last_len == PROG, "R5 busy runs", last_len, PROG);
    chk(ncommit == c0, "R5 no commit", ncommit - c0, 0);
    chk(sect == 7 && bvalid == m && bget(1) == 8'h71, "R5 buffer kept", {sect, bvalid}, {9'd7, m});

    // R4 broken prefix becomes a (blocked) data load
    c0 = ncommit; b0 = nbusy;
    pulse(15'h5555, 8'hAA, 1'b1);
    pulse(15'h2AAA, 8'h56, 1'b1);
    wait_prog(seen);
    chk(nbusy == b0 + 1 && ncommit == c0, "R4 mismatch blocked", {nbusy - b0, ncommit - c0}, {32'd1, 32'd0});

    // R8 foreign sector ignored
    lock_seq();
    pulse(ad(2, 0), 8'h11, 1'b1);
    pulse(ad(4, 1), 8'h22, 1'b1);
    pulse(ad(2, 9), 8'h33, 1'b1);
    wait_prog(seen);
    m = (64'd1 << 0) | (64'd1 << 9);
    chk(sect == 2 && bvalid == m, "R8 foreign sector", {sect, bvalid}, {9'd2, m});
    chk(bget(9) == 8'h33 && bget(0) == 8'h11, "R8 bytes", {bget(0), bget(9)}, 16'h1133);

    // R1 OE low inhibits
    b0 = nbusy;
    pulse(ad(5, 5), 8'h55, 1'b0);
    repeat (3 * IDLE + PROG) @(negedge clk);
    chk(nbusy == b0 && busy == 0, "R1 oe inhibit", nbusy - b0, 0);

    // R6 unlock then commit, then plain load commits
    c0 = ncommit;
    pulse(15'h5555, 8'hAA, 1'b1);
    pulse(15'h2AAA, 8'h55, 1'b1);
    pulse(15'h5555, 8'h80, 1'b1);
    pulse(15'h5555, 8'hAA, 1'b1);
    pulse(15'h2AAA, 8'h55, 1'b1);
    pulse(15'h5555, 8'h20, 1'b1);
    pulse(ad(6, 2), 8'h62, 1'b1);
    wait_prog(seen);
    chk(ncommit == c0 + 1 && sect == 6, "R6 commit", {ncommit - c0, sect}, {32'd1, 9'd6});
    pulse(ad(6, 3), 8'h63, 1'b1);
    wait_prog(seen);
    chk(ncommit == c0 + 2 && bvalid == 64'h8, "R6 stays off", bvalid, 64'h8);

    // R2 address at later fall, data before first rise
    @(negedge clk); addr = ad(1, 10); data = 8'hD1; ce_n = 1'b0;
    repeat (2) @(negedge clk); addr = ad(1, 20);
    repeat (2) @(negedge clk); we_n = 1'b0;
    repeat (2) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk); data = 8'hD2; addr = ad(1, 30);
    repeat (2) @(negedge clk); we_n = 1'b1;
    wait_prog(seen);
    chk(bvalid == (64'd1 << 20), "R2 address", bvalid, 64'd1 << 20);
    chk(bget(20) == 8'hD1, "R2 data", bget(20), 8'hD1);

    // R9/R11 load vs window close, gap sweep
    for (int g = IDLE - 2; g <= IDLE + 2; g++) begin
      c0 = ncommit; b0 = nbusy;
      pulse(ad(8, 0), 8'h80 + 8'(g), 1'b1);
      // last pulse rise happened 3 negedges ago
      @(negedge clk); addr = ad(8, 1); data = 8'h01;
      repeat (g - 6) @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0;
      repeat (2) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      wait_prog(seen);
      repeat (3 * IDLE) @(negedge clk);
      m = (g <= IDLE) ? 64'h3 : 64'h1;
      chk(bvalid == m, (g <= IDLE) ? "R9 load extends" : "R11 load ignored", bvalid, m);
      chk(nbusy == b0 + 1 && ncommit == c0 + 1, "R9 one window",
          {nbusy - b0, ncommit - c0}, {32'd1, 32'd1});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule